// File: doc/BRIEF.md
# Display Timing Generator with Staged Timing Registers

This block produces the horizontal sync, vertical sync and data-enable strobes of a parallel display port, together with the current pixel column and line numbers. It advances one position per clock cycle of its clock, which is the pixel clock, and walks each line and each frame in the order: visible area, front porch, sync pulse, back porch. The visible width and height, the three porch and pulse lengths for each direction, and the polarity of every strobe are set through a small register port.

While the generator runs, timing writes land in a staged copy. They are moved into the working copy in one step at the first cycle of vertical blanking, and only after software has raised a one-shot load request. While it is stopped, the working copy follows the staged copy directly. Clearing the run bit lets the current frame finish, and the bit reads back as set until that happens, so software can poll for the stop. A vertical-blank status flag with write-one-to-clear semantics drives an interrupt through its own mask bit. A self-held software reset bit is raised and dropped through set and clear alias addresses of the control register. A separate display-on bit forces the strobes to their idle levels without stopping the counters.

Top module: `disp_timing_gen`

## Requirements
- R1: The column counter `pix_x` counts 0 to W+HF+HS+HB-1 and wraps to 0. `hsync` is active for HS cycles starting at column W+HF. W is the width field, SIZE[15:0]. HF, HS and HB are HTIM[7:0], HTIM[15:8] and HTIM[23:16].
- R2: The line counter `pix_y` advances only in the cycle after the last column of a line. It wraps after line H+VF+VS+VB-1. `vsync` is active on lines H+VF up to H+VF+VS-1. H is SIZE[31:16]. VF, VS and VB sit in VTIM at the same field positions as in HTIM.
- R3: `de` is active only while `pix_x` < W and `pix_y` < H, the generator is running, and display-on is set. After reset all strobes sit at their idle level of 0.
- R4: CTRL bits 4, 5 and 6 invert `hsync`, `vsync` and `de`. CTRL bit 7 drives `pclk_negedge` directly.
- R5: While the generator runs, writes to SIZE, HTIM or VTIM do not change the strobes until a load request has been honoured. While it is stopped, written timing is used from the next start.
- R6: Writing 1 to CTRL bit 2, directly or through the set alias, raises a load request. The request reads back as 1 until the staged timing is transferred on the first cycle of the first front-porch line, after which it reads 0.
- R7: Setting CTRL bit 0 starts the generator at column 0, line 0 from the next cycle. Clearing it makes bit 0 still read 1 until the last cycle of the frame. Afterwards it reads 0, and the counters hold at 0 with all strobes idle.
- R8: STAT bit 0 becomes 1 at the first cycle of the first front-porch line. Writing 1 to it clears it, and writing 0 leaves it unchanged. `irq` equals STAT bit 0 AND IEN bit 0.
- R9: CTRL bit 8 is a software reset. Writing its mask to the set alias raises it and writing it to the clear alias drops it. While it is held, the counters are 0 and all other CTRL bits and STAT are cleared. SIZE, HTIM, VTIM and IEN keep their values.
- R10: With display-on (CTRL bit 1) cleared, all three strobes sit at their idle level while `pix_x` and `pix_y` keep counting.
- R11: Register addresses are CTRL 0, CTRL set alias 1, CTRL clear alias 2, SIZE 3, HTIM 4, VTIM 5, STAT 6, IEN 7. The set alias ORs data into CTRL and the clear alias clears the bits written as 1. SIZE, HTIM and VTIM read back their staged values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data, combinational |
| hsync | output | 1 | Horizontal sync after polarity |
| vsync | output | 1 | Vertical sync after polarity |
| de | output | 1 | Data enable after polarity |
| pix_x | output | H_W+2 | Current column |
| pix_y | output | H_W+2 | Current line |
| pclk_negedge | output | 1 | Request to launch pixel data on the falling clock edge |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
With the default unregistered output stage, the strobes and coordinates are combinational functions of the counter registers. A register write presented in one cycle therefore shows its effect at the sample point right after the next rising edge. Starting the generator gives column 0, line 0 at that first sample, and the k-th later sample sits k positions further on. The load request clearing, the timing change and the status flag all appear together at the sample for column 0 of line H. The run bit reads 0 at the sample following the last column of the last line. The bench drives stimulus and samples outputs on falling edges only, and it locates each event by waiting for the exact coordinate where the requirement places it.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;

   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_SET  = 4'd1;
   localparam logic [ADDR_W-1:0] A_CLR  = 4'd2;
   localparam logic [ADDR_W-1:0] A_SIZE = 4'd3;
   localparam logic [ADDR_W-1:0] A_HTIM = 4'd4;
   localparam logic [ADDR_W-1:0] A_VTIM = 4'd5;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd6;
   localparam logic [ADDR_W-1:0] A_IEN  = 4'd7;

   localparam int B_EN   = 0;
   localparam int B_DON  = 1;
   localparam int B_SHD  = 2;
   localparam int B_IHS  = 4;
   localparam int B_IVS  = 5;
   localparam int B_IDE  = 6;
   localparam int B_IPCK = 7;
   localparam int B_SRST = 8;
   localparam int CTRL_W = 9;

   localparam int SEG_FP = 0;
   localparam int SEG_PW = 1;
   localparam int SEG_BP = 2;
   localparam int FIELD_STRIDE = 8;
   localparam int SIZE_H_LSB   = 16;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
   import dtg_pkg::*;
#(
   parameter int H_W = 12,
   parameter int P_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [DATA_W-1:0]       rdata,
   input  logic                    frame_end,
   input  logic                    vblank_start,
   output logic [H_W-1:0]          act_w,
   output logic [H_W-1:0]          act_h,
   output logic [2:0][P_W-1:0]     act_hp,
   output logic [2:0][P_W-1:0]     act_vp,
   output logic                    running,
   output logic                    disp_on,
   output logic                    inv_hs,
   output logic                    inv_vs,
   output logic                    inv_de,
   output logic                    inv_pck,
   output logic                    srst,
   output logic                    irq
);
   logic en_req_q, en_act_q, don_q, shd_q, srst_q;
   logic ihs_q, ivs_q, ide_q, ipck_q, stat_q, ien_q;
   logic [H_W-1:0]      stg_w, stg_h, act_w_q, act_h_q;
   logic [2:0][P_W-1:0] stg_hp, stg_vp, act_hp_q, act_vp_q;
   logic [CTRL_W-1:0]   cur, nxt;
   logic wr_ctrl, wr_set, wr_clr, wr_size, wr_htim, wr_vtim, wr_stat, wr_ien;
   logic shd_set, load_now;
   logic unused_wbits;

   assign wr_ctrl = we && (waddr == A_CTRL);
   assign wr_set  = we && (waddr == A_SET);
   assign wr_clr  = we && (waddr == A_CLR);
   assign wr_size = we && (waddr == A_SIZE);
   assign wr_htim = we && (waddr == A_HTIM);
   assign wr_vtim = we && (waddr == A_VTIM);
   assign wr_stat = we && (waddr == A_STAT);
   assign wr_ien  = we && (waddr == A_IEN);

   assign cur = {srst_q, ipck_q, ide_q, ivs_q, ihs_q, 1'b0, shd_q, don_q, en_req_q};

   always_comb begin
      nxt = cur;
      if (wr_ctrl)     nxt = wdata[CTRL_W-1:0];
      else if (wr_set) nxt = cur | wdata[CTRL_W-1:0];
      else if (wr_clr) nxt = cur & ~wdata[CTRL_W-1:0];
   end

   assign shd_set  = (wr_ctrl || wr_set) && wdata[B_SHD];
   assign load_now = !en_act_q || (shd_q && vblank_start);
   assign unused_wbits = ^{wdata, nxt[B_SHD], nxt[3]};

   // control and status state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_req_q <= 1'b0; en_act_q <= 1'b0; don_q <= 1'b0; shd_q <= 1'b0;
         srst_q <= 1'b0; ihs_q <= 1'b0; ivs_q <= 1'b0; ide_q <= 1'b0;
         ipck_q <= 1'b0; stat_q <= 1'b0;
      end else if (srst_q) begin
         en_req_q <= 1'b0; en_act_q <= 1'b0; don_q <= 1'b0; shd_q <= 1'b0;
         ihs_q <= 1'b0; ivs_q <= 1'b0; ide_q <= 1'b0; ipck_q <= 1'b0;
         stat_q <= 1'b0;
         srst_q <= nxt[B_SRST];
      end else begin
         en_req_q <= nxt[B_EN];
         don_q    <= nxt[B_DON];
         ihs_q    <= nxt[B_IHS];
         ivs_q    <= nxt[B_IVS];
         ide_q    <= nxt[B_IDE];
         ipck_q   <= nxt[B_IPCK];
         srst_q   <= nxt[B_SRST];
         en_act_q <= nxt[B_EN] ? 1'b1 : (frame_end ? 1'b0 : en_act_q);
         shd_q    <= shd_set ? 1'b1 : (load_now ? 1'b0 : shd_q);
         stat_q   <= vblank_start ? 1'b1 : ((wr_stat && wdata[0]) ? 1'b0 : stat_q);
      end
   end

   // staged and working timing copies
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_w <= '0; stg_h <= '0; stg_hp <= '0; stg_vp <= '0;
         act_w_q <= '0; act_h_q <= '0; act_hp_q <= '0; act_vp_q <= '0;
         ien_q <= 1'b0;
      end else begin
         if (wr_size) begin
            stg_w <= wdata[H_W-1:0];
            stg_h <= wdata[SIZE_H_LSB +: H_W];
         end
         for (int i = 0; i < 3; i++) begin
            if (wr_htim) stg_hp[i] <= wdata[FIELD_STRIDE*i +: P_W];
            if (wr_vtim) stg_vp[i] <= wdata[FIELD_STRIDE*i +: P_W];
         end
         if (wr_ien) ien_q <= wdata[0];
         if (load_now) begin
            act_w_q  <= stg_w;
            act_h_q  <= stg_h;
            act_hp_q <= stg_hp;
            act_vp_q <= stg_vp;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (raddr)
         A_CTRL, A_SET, A_CLR:
            rdata[CTRL_W-1:0] = {srst_q, ipck_q, ide_q, ivs_q, ihs_q, 1'b0,
                                 shd_q, don_q, en_act_q};
         A_SIZE: begin
            rdata[H_W-1:0]              = stg_w;
            rdata[SIZE_H_LSB +: H_W]    = stg_h;
         end
         A_HTIM: for (int i = 0; i < 3; i++) rdata[FIELD_STRIDE*i +: P_W] = stg_hp[i];
         A_VTIM: for (int i = 0; i < 3; i++) rdata[FIELD_STRIDE*i +: P_W] = stg_vp[i];
         A_STAT: rdata[0] = stat_q;
         A_IEN:  rdata[0] = ien_q;
         default: rdata = '0;
      endcase
   end

   assign act_w   = act_w_q;
   assign act_h   = act_h_q;
   assign act_hp  = act_hp_q;
   assign act_vp  = act_vp_q;
   assign running = en_act_q;
   assign disp_on = don_q;
   assign inv_hs  = ihs_q;
   assign inv_vs  = ivs_q;
   assign inv_de  = ide_q;
   assign inv_pck = ipck_q;
   assign srst    = srst_q;
   assign irq     = stat_q & ien_q;

   assert_shadow_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (shd_q && vblank_start && !srst_q && !shd_set) |=> !shd_q);

   assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_act_q) |-> $past(frame_end || srst_q));

   assert_vblank_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vblank_start && !srst_q) |=> stat_q);
endmodule

// File: rtl/dtg_scan.sv
module dtg_scan #(
   parameter int H_W = 12,
   parameter int P_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                clr,
   input  logic [H_W-1:0]      act_w,
   input  logic [H_W-1:0]      act_h,
   input  logic [2:0][P_W-1:0] hp,
   input  logic [2:0][P_W-1:0] vp,
   output logic [H_W+1:0]      h_o,
   output logic [H_W+1:0]      v_o,
   output logic                frame_end,
   output logic                vblank_start,
   output logic                hs_raw,
   output logic                vs_raw,
   output logic                de_raw
);
   localparam int TW = H_W + 2;

   logic [TW-1:0] h_q, v_q, htot, vtot, hs_beg, hs_end, vs_beg, vs_end;
   logic line_end;

   assign hs_beg = TW'(act_w) + TW'(hp[0]);
   assign hs_end = hs_beg + TW'(hp[1]);
   assign htot   = hs_end + TW'(hp[2]);
   assign vs_beg = TW'(act_h) + TW'(vp[0]);
   assign vs_end = vs_beg + TW'(vp[1]);
   assign vtot   = vs_end + TW'(vp[2]);

   assign line_end     = run && !clr && (h_q == htot - 1'b1);
   assign frame_end    = line_end && (v_q == vtot - 1'b1);
   assign vblank_start = line_end && (v_q == TW'(act_h) - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_q <= '0;
         v_q <= '0;
      end else if (clr || !run) begin
         h_q <= '0;
         v_q <= '0;
      end else if (line_end) begin
         h_q <= '0;
         v_q <= frame_end ? '0 : v_q + 1'b1;
      end else begin
         h_q <= h_q + 1'b1;
      end
   end

   assign hs_raw = (h_q >= hs_beg) && (h_q < hs_end);
   assign vs_raw = (v_q >= vs_beg) && (v_q < vs_end);
   assign de_raw = (h_q < TW'(act_w)) && (v_q < TW'(act_h));
   assign h_o    = h_q;
   assign v_o    = v_q;

   assert_h_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr) |-> (h_q < htot));

   assert_line_step_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clr && !line_end) |=> (v_q == $past(v_q)));

   assert_srst_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (h_q == '0 && v_q == '0));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
   import dtg_pkg::*;
#(
   parameter int H_W     = 12,
   parameter int P_W     = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              hsync,
   output logic              vsync,
   output logic              de,
   output logic [H_W+1:0]    pix_x,
   output logic [H_W+1:0]    pix_y,
   output logic              pclk_negedge,
   output logic              irq
);
   localparam int TW = H_W + 2;

   if (H_W < 2 || H_W > 16) begin : g_bad_hw
      $error("disp_timing_gen: H_W must lie in 2..16");
   end
   if (P_W < 1 || P_W > FIELD_STRIDE) begin : g_bad_pw
      $error("disp_timing_gen: P_W must lie in 1..8");
   end

   logic [H_W-1:0]      act_w, act_h;
   logic [2:0][P_W-1:0] act_hp, act_vp;
   logic running, disp_on, inv_hs, inv_vs, inv_de, inv_pck, srst;
   logic frame_end, vblank_start, hs_raw, vs_raw, de_raw, gate;
   logic hs_n, vs_n, de_n;
   logic [TW-1:0] h_c, v_c;

   dtg_regs #(.H_W(H_W), .P_W(P_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
      .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
      .frame_end(frame_end), .vblank_start(vblank_start),
      .act_w(act_w), .act_h(act_h), .act_hp(act_hp), .act_vp(act_vp),
      .running(running), .disp_on(disp_on), .inv_hs(inv_hs),
      .inv_vs(inv_vs), .inv_de(inv_de), .inv_pck(inv_pck),
      .srst(srst), .irq(irq)
   );

   dtg_scan #(.H_W(H_W), .P_W(P_W)) u_scan (
      .clk(clk), .rst_n(rst_n), .run(running), .clr(srst),
      .act_w(act_w), .act_h(act_h), .hp(act_hp), .vp(act_vp),
      .h_o(h_c), .v_o(v_c), .frame_end(frame_end),
      .vblank_start(vblank_start), .hs_raw(hs_raw), .vs_raw(vs_raw),
      .de_raw(de_raw)
   );

   assign gate = running && disp_on;
   assign hs_n = (hs_raw && gate) ^ inv_hs;
   assign vs_n = (vs_raw && gate) ^ inv_vs;
   assign de_n = (de_raw && gate) ^ inv_de;
   assign pclk_negedge = inv_pck;

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0;
            pix_x <= '0;   pix_y <= '0;
         end else begin
            hsync <= hs_n; vsync <= vs_n; de <= de_n;
            pix_x <= h_c;  pix_y <= v_c;
         end
      end
   end else begin : g_out_comb
      assign hsync = hs_n;
      assign vsync = vs_n;
      assign de    = de_n;
      assign pix_x = h_c;
      assign pix_y = v_c;

      assert_de_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (de != inv_de) |-> (pix_x < TW'(act_w) && pix_y < TW'(act_h) && running && disp_on));

      assert_display_off_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !disp_on |-> (hsync == inv_hs && vsync == inv_vs && de == inv_de));
   end
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
   localparam int CLK_P = 10;
   localparam int H_W = 12;
   localparam int TW = H_W + 2;

   logic clk = 1'b0;
   logic rst_n;
   logic reg_we;
   logic [3:0] reg_waddr, reg_raddr;
   logic [31:0] reg_wdata, reg_rdata;
   logic hsync, vsync, de, pclk_negedge, irq;
   logic [TW-1:0] pix_x, pix_y;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench view of the programmed timing
   int tw = 4, th = 3;
   int hf = 2, hs = 1, hb = 3;
   int vf = 1, vs = 1, vb = 2;

   always #(CLK_P/2) clk = ~clk;

   disp_timing_gen #(.H_W(H_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y),
      .pclk_negedge(pclk_negedge), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // called at a falling edge; returns at the falling edge after the commit
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_pos(input int x, input int y);
      int t = 0;
      while (!(pix_x == TW'(x) && pix_y == TW'(y))) begin
         @(negedge clk);
         t++;
         if (t > 2000) begin
            check("watchdog position", {pix_x[15:0], pix_y[15:0]}, {x[15:0], y[15:0]});
            summary();
         end
      end
   endtask

   function automatic logic [2:0] exp_strobes(input int x, input int y);
      logic d, h, v;
      d = (x < tw) && (y < th);
      h = (x >= tw + hf) && (x < tw + hf + hs);
      v = (y >= th + vf) && (y < th + vf + vs);
      return {d, h, v};
   endfunction

   // R1 R2 R3: one whole frame from column 0, line 0
   task automatic scan_frame(input string req);
      int htot = tw + hf + hs + hb;
      int vtot = th + vf + vs + vb;
      for (int k = 0; k < htot * vtot; k++) begin
         int ex = k % htot;
         int ey = k / htot;
         check(req, {pix_x[13:0], pix_y[13:0], de, hsync, vsync, 1'b0},
                    {ex[13:0], ey[13:0], exp_strobes(ex, ey), 1'b0});
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R3 reset strobes", {29'd0, de, hsync, vsync}, 32'd0);
      check("R3 reset irq", {31'd0, irq}, 32'd0);
      rd(4'd0, d);
      check("R7 reset ctrl", d, 32'd0);
   endtask

   task automatic t_program_run();
      logic [31:0] d;
      wr(4'd3, 32'h0003_0004);
      wr(4'd4, 32'h0003_0102);
      wr(4'd5, 32'h0002_0101);
      rd(4'd3, d); check("R11 size readback", d, 32'h0003_0004);
      rd(4'd4, d); check("R11 htim readback", d, 32'h0003_0102);
      wr(4'd1, 32'h3);
      scan_frame("R1 R2 R3 frame scan");
   endtask

   task automatic t_polarity();
      wr(4'd1, 32'hF0);
      wait_pos(2, 0);
      check("R4 inverted at active", {28'd0, de, hsync, vsync, pclk_negedge}, {28'd0, 4'b0111});
      wait_pos(6, 4);
      check("R4 inverted in sync", {29'd0, de, hsync, vsync}, {29'd0, 3'b100});
      wr(4'd2, 32'hF0);
      check("R4 polarity restored", {30'd0, de, pclk_negedge}, 32'd0);
   endtask

   task automatic t_display_off();
      wr(4'd2, 32'h2);
      wait_pos(2, 1);
      check("R10 de idle, counters run", {29'd0, de, hsync, vsync}, 32'd0);
      wait_pos(6, 4);
      check("R10 syncs idle", {29'd0, de, hsync, vsync}, 32'd0);
      wr(4'd1, 32'h2);
      wait_pos(2, 1);
      check("R10 de back on", {31'd0, de}, 32'd1);
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wait_pos(0, 0);
      wr(4'd7, 32'h1);
      wr(4'd6, 32'h1);
      wait_pos(9, 2);
      rd(4'd6, d);
      check("R8 status clear before blank", {d[30:0], irq}, 32'd0);
      @(negedge clk);
      rd(4'd6, d);
      check("R8 status set at blank start", {d[30:0], irq}, 32'd3);
      wr(4'd6, 32'h0);
      rd(4'd6, d);
      check("R8 write 0 leaves status", d, 32'd1);
      wr(4'd6, 32'h1);
      rd(4'd6, d);
      check("R8 write 1 clears status", {d[30:0], irq}, 32'd0);
      wr(4'd7, 32'h0);
      wait_pos(0, 3);
      rd(4'd6, d);
      check("R8 masked irq", {d[30:0], irq}, 32'd2);
      wr(4'd6, 32'h1);
   endtask

   task automatic t_shadow();
      logic [31:0] d;
      wait_pos(0, 0);
      wr(4'd4, 32'h0001_0203);
      rd(4'd4, d);
      check("R11 staged htim", d, 32'h0001_0203);
      wait_pos(6, 0);
      check("R5 old hsync kept", {31'd0, hsync}, 32'd1);
      wait_pos(7, 0);
      check("R5 old hsync end", {31'd0, hsync}, 32'd0);
      wr(4'd1, 32'h4);
      rd(4'd0, d);
      check("R6 request pending", {31'd0, d[2]}, 32'd1);
      wait_pos(6, 1);
      check("R5 no change before blank", {31'd0, hsync}, 32'd1);
      wait_pos(9, 2);
      rd(4'd0, d);
      check("R6 pending at last active pixel", {31'd0, d[2]}, 32'd1);
      @(negedge clk);
      rd(4'd0, d);
      check("R6 request cleared", {31'd0, d[2]}, 32'd0);
      hf = 3; hs = 2; hb = 1;
      wait_pos(6, 3);
      check("R5 new timing col 6", {31'd0, hsync}, 32'd0);
      @(negedge clk);
      check("R5 new timing col 7", {31'd0, hsync}, 32'd1);
      @(negedge clk);
      check("R5 new timing col 8", {31'd0, hsync}, 32'd1);
      @(negedge clk);
      check("R5 new timing col 9", {31'd0, hsync}, 32'd0);
   endtask

   task automatic t_disable();
      logic [31:0] d;
      wait_pos(0, 1);
      wr(4'd2, 32'h1);
      rd(4'd0, d);
      check("R7 enable still reads 1", {31'd0, d[0]}, 32'd1);
      wait_pos(9, 6);
      rd(4'd0, d);
      check("R7 enable 1 at last pixel", {31'd0, d[0]}, 32'd1);
      @(negedge clk);
      rd(4'd0, d);
      check("R7 enable reads 0 after frame", {31'd0, d[0]}, 32'd0);
      repeat (5) @(negedge clk);
      check("R7 counters held", {pix_x[13:0], pix_y[13:0], de, hsync, vsync, 1'b0}, 32'd0);
   endtask

   task automatic t_stopped_load();
      wr(4'd4, 32'h0003_0102);
      hf = 2; hs = 1; hb = 3;
      wr(4'd1, 32'h1);
      scan_frame("R5 stopped write used at start");
   endtask

   task automatic t_srst();
      logic [31:0] d;
      rd(4'd6, d);
      check("R9 status set before reset", d, 32'd1);
      wr(4'd1, 32'h100);
      @(negedge clk);
      rd(4'd0, d);
      check("R9 ctrl during reset", d, 32'h100);
      rd(4'd6, d);
      check("R9 status cleared", d, 32'd0);
      repeat (3) @(negedge clk);
      check("R9 counters zero", {pix_x[13:0], pix_y[13:0], 4'd0}, 32'd0);
      wr(4'd2, 32'h100);
      rd(4'd0, d);
      check("R9 reset released", d, 32'd0);
      rd(4'd4, d);
      check("R9 timing kept", d, 32'h0003_0102);
   endtask

   initial begin
      #(CLK_P * 100000);
      check("watchdog", 32'd1, 32'd0);
      summary();
   end

   initial begin
      rst_n = 1'b0; reg_we = 1'b0; reg_waddr = '0; reg_wdata = '0; reg_raddr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program_run();
      t_polarity();
      t_display_off();
      t_irq();
      t_shadow();
      t_disable();
      t_stopped_load();
      t_srst();
      summary();
   end
endmodule